// File: doc/BRIEF.md
# Sequenced Boot Reply Filter

This block sits on the receive side of a network boot loader. It takes the 16-bit words of incoming frames from a receive FIFO, one word per cycle when `rx_valid` is high, with `rx_eop` marking the last word of a frame. It keeps only boot reply frames that meet all of these conditions:

- they are addressed to this station;
- they carry the boot file number that was requested;
- they carry the next sequence number in the download.

The payload words of each kept frame go to a memory write port at consecutive addresses. The address run continues from one accepted frame to the next, so the downloaded file lands in memory as one contiguous image.

A `start` pulse arms a download. It sets the expected sequence number to 1 and the write address to `BASE_ADDR`. The sender of the first frame that passes the checks becomes the only source accepted for the rest of the download. A frame with a byte length of 40 carries no data and ends the download. It raises `last_seen` and leaves the filter idle until the next `start`.

Each frame ends in one of two ways. A fully accepted frame gives a one-cycle `pkt_accept`. A rejected or truncated frame gives a one-cycle `pkt_discard`. Checking the whole file is left to the logic that uses this block.

Top module: `boot_reply_filter`

Frame layout by word index (index 0 is the first word after the start of the frame):

| Index | Content |
|---|---|
| 0–2 | Destination station address |
| 3–5 | Source station address |
| 6 | Type word |
| 7 | Protocol checksum |
| 8 | Byte length |
| 9–22 | Skipped header words |
| 23–25 | Boot file number |
| 26 | Sequence number |
| 27 onward | Payload, then pad and CRC words |

## Requirements
- R1: Until the first `start` pulse, and after the download has ended, every frame is dropped silently: no write, no `pkt_accept` and no `pkt_discard`.
- R2: Words 0, 1 and 2 must equal `host_addr[47:32]`, `host_addr[31:16]` and `host_addr[15:0]`. A mismatch rejects the frame.
- R3: Word 6 must be 16'h0600. Word 7, the protocol checksum, may hold any value and has no effect.
- R4: Word 8 is the byte length. A value below 40 rejects the frame. Otherwise the payload holds (length − 39) / 2 words, rounded down, so an odd excess rounds up to a whole word.
- R5: Words 23, 24 and 25 must equal 16'h0000, `file_num[31:16]` and `file_num[15:0]`.
- R6: Word 26 must equal the expected sequence number. `start` sets it to 1, and each accepted frame increments it by one.
- R7: While the expected sequence number is 1, words 3 to 5 of a frame are stored as the source address, without being compared. In every later frame, words 3 to 5 must equal the stored source.
- R8: Payload word k of a frame is written, one cycle after it arrives, to the address base + k. The base is `BASE_ADDR` after `start` and grows by the payload count of each accepted frame.
- R9: Pad and CRC words after the payload are never written. `pkt_accept` rises for one cycle, one cycle after the end-of-packet word of a frame that passed every check and delivered its whole payload.
- R10: A frame that ends before word 26 or before its last payload word is discarded. The expected sequence number and the base stay unchanged, so the next accepted frame writes over the same addresses.
- R11: An accepted frame with a payload count of zero sets `last_seen` in the same cycle as its `pkt_accept`. It then stops the filter (see R1). `start` clears `last_seen` and rearms the filter.
- R12: `pkt_discard` is a one-cycle pulse, one cycle after the first failing word (or after a premature end-of-packet word). The rest of that frame is then ignored. `pkt_discard` and `pkt_accept` never rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms a new download |
| rx_valid | input | 1 | `rx_data` holds a frame word this cycle |
| rx_data | input | 16 | Frame word |
| rx_eop | input | 1 | This word is the last word of the frame |
| host_addr | input | 48 | This station's address, first frame word in the top bits |
| file_num | input | 32 | Lower two words of the requested boot file number |
| mem_we | output | 1 | Payload write strobe |
| mem_addr | output | ADDR_W | Payload write address |
| mem_wdata | output | 16 | Payload write data |
| pkt_discard | output | 1 | Frame rejected or cut short |
| pkt_accept | output | 1 | Frame accepted |
| last_seen | output | 1 | Final, empty frame accepted |

## Verification
The bench builds frames of the boot reply layout, tampers with one field at a time, and compares every output on every cycle against a behavioural model. This shows that each header field rejects the frame on its own, and that the checksum word and the pad words do not.

Several frame shapes are used:
- stale and skipped sequence numbers, and a foreign sender;
- frames cut short inside the header and inside the payload, followed by a good retry;
- odd and even byte lengths;
- frames sent back to back;
- an empty frame whose end-of-packet falls on the sequence word.

Together these separate the address-rollback and sequence-keeping behaviour from plain field matching. A second download with a different sender then confirms that `start` resets the address, the sequence number and the locked source.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int WORD_W = 16;
    localparam int IX_W   = 5;
    localparam int CNT_W  = 15;

    // word positions inside a reply frame (decoded by neighbours, so fixed)
    localparam logic [IX_W-1:0] IX_SRC0  = 5'd3;
    localparam logic [IX_W-1:0] IX_TYPE  = 5'd6;
    localparam logic [IX_W-1:0] IX_LEN   = 5'd8;
    localparam logic [IX_W-1:0] IX_FILE0 = 5'd23;
    localparam logic [IX_W-1:0] IX_FILE1 = 5'd24;
    localparam logic [IX_W-1:0] IX_FILE2 = 5'd25;
    localparam logic [IX_W-1:0] IX_SEQ   = 5'd26;

    localparam logic [WORD_W-1:0] BOOT_ETYPE = 16'h0600;
    localparam logic [WORD_W-1:0] LEN_EMPTY  = 16'd40;

    typedef enum logic [1:0] {
        PH_HDR,
        PH_DATA,
        PH_TAIL,
        PH_DROP
    } phase_e;

    typedef struct packed {
        logic             fire;
        logic             empty;
        logic [CNT_W-1:0] words;
    } commit_t;

    // payload words carried by a frame of the given byte length (length >= 40)
    function automatic logic [CNT_W-1:0] payload_words(input logic [WORD_W-1:0] len);
        return CNT_W'((len - 16'd39) >> 1);
    endfunction

endpackage

// File: rtl/brf_hdr_check.sv
module brf_hdr_check
    import brf_pkg::*;
(
    input  logic [IX_W-1:0]   idx,
    input  logic [WORD_W-1:0] word,
    input  logic [47:0]       host,
    input  logic [47:0]       src,
    input  logic [31:0]       file,
    input  logic [WORD_W-1:0] exp_seq,
    input  logic              first,
    output logic              ok
);
    logic [3:0] dst_hit;
    logic [3:0] src_hit;
    logic [1:0] src_sel;

    assign dst_hit[3] = 1'b0;
    assign src_hit[3] = 1'b0;

    for (genvar k = 0; k < 3; k++) begin : g_addr_word
        assign dst_hit[k] = (word == host[47-16*k -: 16]);
        assign src_hit[k] = (word == src[47-16*k -: 16]);
    end

    assign src_sel = idx[1:0] + 2'd1;

    always_comb begin
        ok = 1'b1;
        if (idx < IX_SRC0) begin
            ok = dst_hit[idx[1:0]];
        end else if (idx < IX_TYPE) begin
            ok = first || src_hit[src_sel];
        end else begin
            case (idx)
                IX_TYPE:  ok = (word == BOOT_ETYPE);
                IX_LEN:   ok = (word >= LEN_EMPTY);
                IX_FILE0: ok = (word == '0);
                IX_FILE1: ok = (word == file[31:16]);
                IX_FILE2: ok = (word == file[15:0]);
                IX_SEQ:   ok = (word == exp_seq);
                default:  ok = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/brf_session.sv
module brf_session
    import brf_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  commit_t           commit,
    input  logic              cap_en,
    input  logic [1:0]        cap_sel,
    input  logic [WORD_W-1:0] cap_word,
    output logic              active,
    output logic [WORD_W-1:0] exp_seq,
    output logic [47:0]       src,
    output logic [ADDR_W-1:0] base,
    output logic              last
);
    logic [2:0][WORD_W-1:0] src_q;

    assign src = src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            exp_seq <= 16'd1;
            base    <= BASE_ADDR;
            last    <= 1'b0;
            src_q   <= '0;
        end else if (start) begin
            active  <= 1'b1;
            exp_seq <= 16'd1;
            base    <= BASE_ADDR;
            last    <= 1'b0;
        end else begin
            if (cap_en) begin
                src_q[2'd2 - cap_sel] <= cap_word;
            end
            if (commit.fire) begin
                exp_seq <= exp_seq + 16'd1;
                base    <= base + ADDR_W'(commit.words);
                if (commit.empty) begin
                    last   <= 1'b1;
                    active <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/brf_parser.sv
module brf_parser
    import brf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_eop,
    input  logic              active,
    input  logic              first,
    input  logic              hdr_ok,
    input  logic [ADDR_W-1:0] base,
    output logic [IX_W-1:0]   idx,
    output commit_t           commit,
    output logic              cap_en,
    output logic [1:0]        cap_sel,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              accept,
    output logic              discard
);
    phase_e           ph, ph_n;
    logic [IX_W-1:0]  idx_n;
    logic [CNT_W-1:0] cnt, cnt_n, pos, pos_n;
    logic             we_n, acc_n, disc_n;

    assign cap_sel = idx[1:0] + 2'd1;

    always_comb begin
        ph_n   = ph;
        idx_n  = idx;
        cnt_n  = cnt;
        pos_n  = pos;
        we_n   = 1'b0;
        acc_n  = 1'b0;
        disc_n = 1'b0;
        cap_en = 1'b0;
        if (rx_valid) begin
            unique case (ph)
                PH_HDR: begin
                    if (!active) begin
                        ph_n = PH_DROP;
                    end else if (!hdr_ok) begin
                        disc_n = 1'b1;
                        ph_n   = PH_DROP;
                    end else begin
                        idx_n = idx + 1'b1;
                        if (idx == IX_LEN) cnt_n = payload_words(rx_data);
                        if (first && idx >= IX_SRC0 && idx < IX_TYPE) cap_en = 1'b1;
                        if (idx == IX_SEQ) begin
                            ph_n  = (cnt == '0) ? PH_TAIL : PH_DATA;
                            pos_n = '0;
                            if (rx_eop) begin
                                acc_n  = (cnt == '0);
                                disc_n = (cnt != '0);
                            end
                        end else if (rx_eop) begin
                            disc_n = 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    we_n  = 1'b1;
                    pos_n = pos + 1'b1;
                    if (pos_n == cnt) ph_n = PH_TAIL;
                    if (rx_eop) begin
                        acc_n  = (pos_n == cnt);
                        disc_n = (pos_n != cnt);
                    end
                end
                PH_TAIL: acc_n = rx_eop;
                PH_DROP: ;
            endcase
            if (rx_eop) begin
                ph_n  = PH_HDR;
                idx_n = '0;
            end
        end
    end

    assign commit.fire  = acc_n;
    assign commit.empty = (cnt == '0);
    assign commit.words = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_HDR;
            idx       <= '0;
            cnt       <= '0;
            pos       <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            accept    <= 1'b0;
            discard   <= 1'b0;
        end else begin
            ph        <= ph_n;
            idx       <= idx_n;
            cnt       <= cnt_n;
            pos       <= pos_n;
            mem_we    <= we_n;
            mem_addr  <= base + ADDR_W'(pos);
            mem_wdata <= rx_data;
            accept    <= acc_n;
            discard   <= disc_n;
        end
    end
endmodule

// File: rtl/boot_reply_filter.sv
module boot_reply_filter
    import brf_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rx_valid,
    input  logic [15:0]       rx_data,
    input  logic              rx_eop,
    input  logic [47:0]       host_addr,
    input  logic [31:0]       file_num,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              pkt_discard,
    output logic              pkt_accept,
    output logic              last_seen
);
    commit_t           commit;
    logic              active, first, hdr_ok, cap_en;
    logic [1:0]        cap_sel;
    logic [IX_W-1:0]   idx;
    logic [WORD_W-1:0] exp_seq;
    logic [47:0]       src;
    logic [ADDR_W-1:0] base;

    assign first = (exp_seq == 16'd1);

    brf_hdr_check u_check (
        .idx     (idx),
        .word    (rx_data),
        .host    (host_addr),
        .src     (src),
        .file    (file_num),
        .exp_seq (exp_seq),
        .first   (first),
        .ok      (hdr_ok)
    );

    brf_parser #(.ADDR_W(ADDR_W)) u_parser (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_eop    (rx_eop),
        .active    (active),
        .first     (first),
        .hdr_ok    (hdr_ok),
        .base      (base),
        .idx       (idx),
        .commit    (commit),
        .cap_en    (cap_en),
        .cap_sel   (cap_sel),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .accept    (pkt_accept),
        .discard   (pkt_discard)
    );

    brf_session #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_session (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .commit   (commit),
        .cap_en   (cap_en),
        .cap_sel  (cap_sel),
        .cap_word (rx_data),
        .active   (active),
        .exp_seq  (exp_seq),
        .src      (src),
        .base     (base),
        .last     (last_seen)
    );
endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              rx_valid,
    input logic              rx_eop,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pkt_discard,
    input logic              pkt_accept,
    input logic              last_seen
);
    p_no_clash_r12: assert property (@(posedge clk) disable iff (rst)
        !(pkt_accept && pkt_discard));

    p_discard_after_word_r12: assert property (@(posedge clk) disable iff (rst)
        pkt_discard |-> $past(rx_valid));

    p_accept_after_eop_r9: assert property (@(posedge clk) disable iff (rst)
        pkt_accept |-> $past(rx_valid && rx_eop));

    p_accept_single_r9: assert property (@(posedge clk) disable iff (rst)
        pkt_accept |=> !pkt_accept);

    p_write_after_word_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(rx_valid));

    p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    p_last_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (last_seen && !start) |=> last_seen);

    p_quiet_after_last_r1: assert property (@(posedge clk) disable iff (rst)
        (last_seen && $past(last_seen)) |-> (!pkt_accept && !mem_we && !pkt_discard));
endmodule

bind boot_reply_filter brf_checker #(.ADDR_W(ADDR_W)) u_brf_checker (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .rx_valid    (rx_valid),
    .rx_eop      (rx_eop),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .pkt_discard (pkt_discard),
    .pkt_accept  (pkt_accept),
    .last_seen   (last_seen)
);

// File: tb/boot_reply_filter_test.sv
module boot_reply_filter_test;
    localparam int BASE = 'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_eop = 1'b0;
    logic [47:0] host_addr = 48'h0A0B_0C0D_0E0F;
    logic [31:0] file_num  = 32'hAA00_0012;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        pkt_discard, pkt_accept, last_seen;

    always #4 clk = ~clk;

    boot_reply_filter uut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_eop      (rx_eop),
        .host_addr   (host_addr),
        .file_num    (file_num),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .pkt_discard (pkt_discard),
        .pkt_accept  (pkt_accept),
        .last_seen   (last_seen)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int          m_active = 0, m_seq = 1, m_base = BASE, m_last = 0;
    int          m_dead = 0, m_nd = 0, m_idx = 0;
    logic [15:0] m_src [3];
    bit          e_we, e_acc, e_disc;
    logic [15:0] e_addr, e_data;
    logic [15:0] fw [$];

    localparam logic [47:0] SRC_A = 48'h5001_5002_5003;
    localparam logic [47:0] SRC_B = 48'h6001_6002_6003;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit field_bad(input int idx, input logic [15:0] w);
        case (idx)
            0, 1, 2: return w != host_addr[47-16*idx -: 16];
            3, 4, 5: return (m_seq != 1) && (w != m_src[idx-3]);
            6:       return w != 16'h0600;
            8:       return int'(w) < 40;
            23:      return w != 16'h0000;
            24:      return w != file_num[31:16];
            25:      return w != file_num[15:0];
            26:      return int'(w) != m_seq;
            default: return 1'b0;
        endcase
    endfunction

    task automatic m_accept();
        e_acc = 1'b1;
        m_seq++;
        m_base += m_nd;
        if (m_nd == 0) begin
            m_last   = 1;
            m_active = 0;
        end
    endtask

    task automatic model_word(input logic [15:0] w, input bit e);
        int idx;
        idx = m_idx;
        m_idx++;
        if (m_dead == 0) begin
            if (m_active == 0) begin
                m_dead = 1;
            end else if (idx < 27) begin
                if (field_bad(idx, w)) begin
                    e_disc = 1'b1;
                    m_dead = 1;
                end else begin
                    if (idx == 8) m_nd = (int'(w) - 39) / 2;
                    if (idx >= 3 && idx <= 5 && m_seq == 1) m_src[idx-3] = w;
                    if (e) begin
                        if (idx == 26 && m_nd == 0) m_accept();
                        else e_disc = 1'b1;
                    end
                end
            end else begin
                int d;
                d = idx - 27;
                if (d < m_nd) begin
                    e_we   = 1'b1;
                    e_addr = 16'(m_base + d);
                    e_data = w;
                end
                if (e) begin
                    if (d >= m_nd - 1) m_accept();
                    else e_disc = 1'b1;
                end
            end
        end
        if (e) begin
            m_idx  = 0;
            m_dead = 0;
        end
    endtask

    task automatic cyc(input bit v, input logic [15:0] w, input bit e, input bit st, input string tag);
        @(negedge clk);
        rx_valid = v;
        rx_data  = w;
        rx_eop   = e;
        start    = st;
        e_we = 1'b0; e_acc = 1'b0; e_disc = 1'b0;
        if (st) begin
            m_active = 1; m_seq = 1; m_base = BASE; m_last = 0;
        end else if (v) begin
            model_word(w, e);
        end
        @(posedge clk);
        #1;
        chk(mem_we == e_we, tag, "mem_we", int'(mem_we), int'(e_we));
        if (e_we) begin
            chk(mem_addr == e_addr, tag, "mem_addr", int'(mem_addr), int'(e_addr));
            chk(mem_wdata == e_data, tag, "mem_wdata", int'(mem_wdata), int'(e_data));
        end
        chk(pkt_accept == e_acc, tag, "pkt_accept", int'(pkt_accept), int'(e_acc));
        chk(pkt_discard == e_disc, tag, "pkt_discard", int'(pkt_discard), int'(e_disc));
        chk(int'(last_seen) == m_last, tag, "last_seen", int'(last_seen), m_last);
    endtask

    task automatic build(input logic [47:0] s, input int len, input int seq, input int present, input bit trunc);
        fw.delete();
        for (int k = 0; k < 3; k++) fw.push_back(host_addr[47-16*k -: 16]);
        for (int k = 0; k < 3; k++) fw.push_back(s[47-16*k -: 16]);
        fw.push_back(16'h0600);
        fw.push_back(16'(seq * 3 + 16'h1234));
        fw.push_back(16'(len));
        for (int k = 0; k < 14; k++) fw.push_back(16'(k * 7 + 1));
        fw.push_back(16'h0000);
        fw.push_back(file_num[31:16]);
        fw.push_back(file_num[15:0]);
        fw.push_back(16'(seq));
        for (int k = 0; k < present; k++) fw.push_back(16'(16'hD000 + seq * 16 + k));
        if (!trunc) begin
            while (fw.size() < 30) fw.push_back(16'h0000);
            fw.push_back(16'hC3C3);
            fw.push_back(16'h3C3C);
        end
    endtask

    task automatic send(input string tag, input bit gap);
        for (int i = 0; i < fw.size(); i++) cyc(1'b1, fw[i], i == fw.size() - 1, 1'b0, tag);
        if (gap) cyc(1'b0, 16'h0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!mem_we && !pkt_accept && !pkt_discard, "R12 reset", "pulses", 0, 0);
        chk(!last_seen, "R11 reset", "last_seen", int'(last_seen), 0);

        build(SRC_A, 50, 1, 5, 1'b0); send("R1 before start", 1'b1);
        cyc(1'b0, 16'h0, 1'b0, 1'b1, "R6 start");
        build(SRC_A, 50, 1, 5, 1'b0); send("R8 first packet", 1'b1);
        build(SRC_A, 48, 2, 4, 1'b0); fw[1] = fw[1] ^ 16'h0001; send("R2 dest word1", 1'b1);
        build(SRC_A, 48, 2, 4, 1'b0); fw[2] = 16'hFFFF; send("R2 dest word2", 1'b1);
        build(SRC_A, 48, 2, 4, 1'b0); fw[6] = 16'h0800; send("R3 type", 1'b1);
        build(SRC_A, 45, 2, 3, 1'b0); fw[7] = 16'hFFFF; send("R3 R4 odd length", 1'b1);
        build(SRC_A, 38, 3, 0, 1'b0); send("R4 short length", 1'b1);
        build(SRC_A, 44, 3, 2, 1'b0); fw[23] = 16'h0001; send("R5 file word0", 1'b1);
        build(SRC_A, 44, 3, 2, 1'b0); fw[25] = fw[25] ^ 16'h0010; send("R5 file word2", 1'b1);
        build(SRC_A, 44, 2, 2, 1'b0); send("R6 stale sequence", 1'b1);
        build(SRC_A, 44, 4, 2, 1'b0); send("R6 skipped sequence", 1'b1);
        build(SRC_B, 44, 3, 2, 1'b0); send("R7 foreign source", 1'b1);
        build(SRC_A, 60, 3, 4, 1'b1); send("R10 payload cut", 1'b1);
        build(SRC_A, 44, 3, 2, 1'b0);
        while (fw.size() > 10) void'(fw.pop_back());
        send("R10 header cut", 1'b1);
        build(SRC_A, 44, 3, 2, 1'b0); send("R10 retry rewrites", 1'b1);
        build(SRC_A, 42, 4, 1, 1'b0); send("R12 back-to-back", 1'b0);
        build(SRC_A, 44, 5, 2, 1'b0); send("R9 pad not stored", 1'b1);
        build(SRC_A, 40, 6, 0, 1'b1); send("R11 empty final", 1'b1);
        build(SRC_A, 44, 7, 2, 1'b0); send("R1 after last", 1'b1);
        cyc(1'b0, 16'h0, 1'b0, 1'b1, "R11 restart");
        build(SRC_B, 44, 1, 2, 1'b0); send("R11 new download", 1'b1);
        build(SRC_A, 44, 2, 2, 1'b0); send("R7 old source locked out", 1'b1);
        build(SRC_B, 46, 2, 3, 1'b0); send("R7 locked source", 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule